// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Periodic Timer

This block keeps time for a larger chip. A 40-bit counter advances once for each 32.768 kHz tick enable it receives, which is a step of about 30.517 µs. At that rate it runs for roughly 388 days before it wraps. A 40-bit alarm value is compared with the counter. Separately, a 16-bit down-counter runs from a faster tick of about 0.868 µs and gives periodic expiries of up to about 56.8 ms. The tick enables come from outside; this block makes no clocks of its own.

Three events set sticky status bits. The first is an alarm match. The second is a periodic timer expiry. The third is an early warning raised when the counter reaches a fixed value 256 steps before it wraps. A mask combines the status bits into a single interrupt line. Software loads and reads every register through a small register bus with eight word addresses. Read data appears one cycle after the read strobe. A read of the counter's low word also latches the counter's upper byte, so a 40-bit value read in two accesses is never torn.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After synchronous reset, every register reads zero: counter, alarm, period, timer enable, status and interrupt mask. The interrupt output and read data are low.
- R2: Each cycle with the counter tick high and no counter write, the 40-bit counter grows by one. It wraps from 0xFF_FFFF_FFFF to zero.
- R3: A write to address 0 loads counter bits 31:0 from write data. A write to address 1 loads counter bits 39:32 from write data bits 7:0. A counter write in the same cycle as a tick takes priority, and that tick is lost.
- R4: A read of address 0 returns counter bits 31:0 and latches bits 39:32. A read of address 1 returns that latched byte in bits 7:0, with bits 31:8 zero, even if the counter has moved on since. Addresses 2 and 3 hold the alarm low word and high byte in the same layout.
- R5: Status bit 0 (alarm) is set when a tick moves the counter onto the alarm value. A bus load that makes the counter equal to the alarm does not set it.
- R6: Status bit 2 (wrap warning) is set when a tick moves the counter onto 0xFF_FFFF_FF00.
- R7: Address 4 holds the 16-bit period. Writing 1 to bit 0 of address 5 while the timer is disabled starts it from the period. While enabled, status bit 1 is set once every max(period,1) timer ticks, and the count reloads from the period each time. While disabled, timer ticks have no effect.
- R8: Writing address 6 clears each status bit whose write-data bit is 1 and leaves the others. If an event sets a bit in the same cycle, the set wins.
- R9: Address 7 is a 3-bit interrupt mask with the same bit order as status. The interrupt output is high exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_tick | input | 1 | One-cycle enable, 32.768 kHz rate, advances counter |
| tmr_tick | input | 1 | One-cycle enable for the periodic timer |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Masked OR of the sticky status bits |

## Verification
The collision that matters is a status event arriving in the same cycle as a software write-one-to-clear of that bit. The bench provokes it by driving a timer tick that expires the period-1 timer together with a clear of bit 1. It then expects the interrupt to remain asserted. A second collision is a counter load together with a tick. There the bench expects the loaded value, not the loaded value plus one. The timer sweep runs every period from 0 to 8, plus 300. For each period, the bench counts the ticks between two expiries and compares the count with max(period,1).

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;
    localparam int IRQ_N  = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CNT_LO = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_ALM_LO = 3'd2,
        REG_ALM_HI = 3'd3,
        REG_PERIOD = 3'd4,
        REG_CTRL   = 3'd5,
        REG_STATUS = 3'd6,
        REG_IRQ_EN = 3'd7
    } reg_addr_e;

    // bit order: alarm = 0, timer = 1, warn = 2
    typedef struct packed {
        logic warn;
        logic timer;
        logic alarm;
    } irq_vec_t;

    function automatic logic [BUS_W-1:0] widen8(input logic [7:0] v);
        return {{(BUS_W-8){1'b0}}, v};
    endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter import rtc_pkg::*; #(
    parameter int CNT_W    = 40,
    parameter int WARN_GAP = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] cnt,
    output logic             alarm_evt,
    output logic             warn_evt
);
    localparam int HI_W = CNT_W - BUS_W;
    localparam logic [CNT_W-1:0] WARN_AT = {CNT_W{1'b1}} - CNT_W'(WARN_GAP - 1);

    logic [CNT_W-1:0] nxt;
    logic             adv;

    assign nxt       = cnt + CNT_W'(1);
    assign adv       = tick && !(ld_lo || ld_hi);
    assign alarm_evt = adv && (nxt == alarm);
    assign warn_evt  = adv && (nxt == WARN_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cnt[BUS_W-1:0]     <= wdata;
            if (ld_hi) cnt[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
        end else if (tick) begin
            cnt <= nxt;
        end
    end

    assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !ld_lo && !ld_hi) |=> (cnt == $past(cnt) + CNT_W'(1)));
    assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
        ld_lo |=> (cnt[BUS_W-1:0] == $past(wdata)));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld_lo && !ld_hi) |=> $stable(cnt));
    assert_alarm_R5: assert property (@(posedge clk) disable iff (rst)
        alarm_evt |=> (cnt == $past(alarm)));
    assert_warn_R6: assert property (@(posedge clk) disable iff (rst)
        warn_evt |=> (cnt == WARN_AT));
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic [TMR_W-1:0] period,
    output logic             en,
    output logic             expire
);
    logic [TMR_W-1:0] cnt;
    logic             last;

    assign last   = (cnt <= TMR_W'(1));
    assign expire = en && tick && !en_wr && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= 1'b0;
            cnt <= '0;
        end else if (en_wr) begin
            en <= en_val;
            if (en_val && !en) cnt <= period;
        end else if (en && tick) begin
            if (last) cnt <= period;
            else      cnt <= cnt - TMR_W'(1);
        end
    end

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == $past(period)));
    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!en && !en_wr) |=> $stable(cnt));
    assert_step_R7: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !en_wr && !last) |=> (cnt == $past(cnt) - TMR_W'(1)));
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq import rtc_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  irq_vec_t         set,
    input  logic             clr_wr,
    input  logic [IRQ_N-1:0] clr_mask,
    input  logic             en_wr,
    input  logic [IRQ_N-1:0] en_val,
    output logic [IRQ_N-1:0] status,
    output logic [IRQ_N-1:0] mask,
    output logic             irq
);
    logic [IRQ_N-1:0] set_v;
    logic [IRQ_N-1:0] clr_v;

    assign set_v = set;
    assign clr_v = clr_wr ? clr_mask : '0;
    assign irq   = |(status & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr_v) | set_v;
            if (en_wr) mask <= en_val;
        end
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((status & $past(set_v)) == $past(set_v)));
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> (($past(status) & ~status) == '0));
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        (!(|set_v) && !en_wr) |=> ($stable(status) || $past(clr_wr)));
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer import rtc_pkg::*; #(
    parameter int CNT_W    = 40,
    parameter int TMR_W    = 16,
    parameter int WARN_GAP = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rtc_tick,
    input  logic              tmr_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int HI_W = CNT_W - BUS_W;

    reg_addr_e        addr;
    logic [CNT_W-1:0] cnt, alarm;
    logic [TMR_W-1:0] period;
    logic [HI_W-1:0]  shadow;
    logic             tmr_en, tmr_exp, alarm_evt, warn_evt;
    logic [IRQ_N-1:0] status, mask;
    irq_vec_t         evt;

    assign addr = reg_addr_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm  <= '0;
            period <= '0;
        end else if (bus_wr) begin
            if (addr == REG_ALM_LO) alarm[BUS_W-1:0]     <= bus_wdata;
            if (addr == REG_ALM_HI) alarm[CNT_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
            if (addr == REG_PERIOD) period               <= bus_wdata[TMR_W-1:0];
        end
    end

    rtc_counter #(.CNT_W(CNT_W), .WARN_GAP(WARN_GAP)) u_cnt (
        .clk(clk), .rst(rst), .tick(rtc_tick),
        .ld_lo(bus_wr && addr == REG_CNT_LO),
        .ld_hi(bus_wr && addr == REG_CNT_HI),
        .wdata(bus_wdata), .alarm(alarm), .cnt(cnt),
        .alarm_evt(alarm_evt), .warn_evt(warn_evt)
    );

    rtc_periodic #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .tick(tmr_tick),
        .en_wr(bus_wr && addr == REG_CTRL), .en_val(bus_wdata[0]),
        .period(period), .en(tmr_en), .expire(tmr_exp)
    );

    always_comb begin
        evt.alarm = alarm_evt;
        evt.timer = tmr_exp;
        evt.warn  = warn_evt;
    end

    rtc_irq u_irq (
        .clk(clk), .rst(rst), .set(evt),
        .clr_wr(bus_wr && addr == REG_STATUS), .clr_mask(bus_wdata[IRQ_N-1:0]),
        .en_wr(bus_wr && addr == REG_IRQ_EN), .en_val(bus_wdata[IRQ_N-1:0]),
        .status(status), .mask(mask), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            shadow    <= '0;
        end else if (bus_rd) begin
            case (addr)
                REG_CNT_LO: begin
                    bus_rdata <= cnt[BUS_W-1:0];
                    shadow    <= cnt[CNT_W-1:BUS_W];
                end
                REG_CNT_HI: bus_rdata <= widen8(8'(shadow));
                REG_ALM_LO: bus_rdata <= alarm[BUS_W-1:0];
                REG_ALM_HI: bus_rdata <= widen8(8'(alarm[CNT_W-1:BUS_W]));
                REG_PERIOD: bus_rdata <= BUS_W'(period);
                REG_CTRL:   bus_rdata <= BUS_W'(tmr_en);
                REG_STATUS: bus_rdata <= BUS_W'(status);
                REG_IRQ_EN: bus_rdata <= BUS_W'(mask);
            endcase
        end
    end

    assert_lo_read_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && addr == REG_CNT_LO) |=> (bus_rdata == $past(cnt[BUS_W-1:0])));
    assert_hi_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && addr == REG_CNT_HI) |=> (bus_rdata[BUS_W-1:HI_W] == '0));
    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_rtc_alarm_timer.sv
module test_rtc_alarm_timer;
    logic        clk = 1'b0, rst = 1'b1, rtc_tick = 1'b0, tmr_tick = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    rtc_alarm_timer i_rtc_alarm_timer (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic rtc_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rtc_tick = 1;
            @(negedge clk); rtc_tick = 0;
        end
    endtask

    task automatic tmr_one();
        @(negedge clk); tmr_tick = 1;
        @(negedge clk); tmr_tick = 0;
    endtask

    task automatic load_cnt(input logic [7:0] hi, input logic [31:0] lo);
        wr(3'd1, {24'd0, hi});
        wr(3'd0, lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values
        check("R1 rdata", bus_rdata, 0);
        check("R1 irq", {31'd0, irq}, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg", d, 0);
        end
        // R3/R4: load and read back, high byte limited to 8 bits
        load_cnt(8'hAB, 32'h1234_5678);
        rd(3'd0, d); check("R4 lo", d, 32'h1234_5678);
        rd(3'd1, d); check("R4 hi", d, 32'h0000_00AB);
        wr(3'd1, 32'hFFFF_FF5A);
        rd(3'd0, d); rd(3'd1, d); check("R3 hi width", d, 32'h5A);
        // R2: advance counts
        wr(3'd2, 32'hDEAD_0000); wr(3'd3, 32'h77);
        for (int n = 1; n <= 6; n++) begin
            load_cnt(8'h00, 32'h0);
            rtc_ticks(n);
            rd(3'd0, d); check("R2 count", d, n);
        end
        // R2: wrap to zero
        load_cnt(8'hFF, 32'hFFFF_FFFF);
        rtc_ticks(1);
        rd(3'd0, d); check("R2 wrap lo", d, 0);
        rd(3'd1, d); check("R2 wrap hi", d, 0);
        // R4: torn-read protection
        load_cnt(8'h05, 32'hFFFF_FFFF);
        rd(3'd0, d); check("R4 capture lo", d, 32'hFFFF_FFFF);
        rtc_ticks(1);
        rd(3'd1, d); check("R4 shadow held", d, 32'h05);
        rd(3'd0, d); check("R4 new lo", d, 0);
        rd(3'd1, d); check("R4 new hi", d, 32'h06);
        // R3: load wins over simultaneous tick
        @(negedge clk); bus_wr = 1; bus_addr = 3'd0; bus_wdata = 32'd100; rtc_tick = 1;
        @(negedge clk); bus_wr = 0; rtc_tick = 0;
        rd(3'd0, d); check("R3 load priority", d, 100);
        // R5: alarm on tick onto match, not on load
        wr(3'd2, 32'h0000_1000); wr(3'd3, 32'h01);
        rd(3'd2, d); check("R4 alarm lo", d, 32'h1000);
        rd(3'd3, d); check("R4 alarm hi", d, 32'h01);
        load_cnt(8'h01, 32'h0000_1000);
        wr(3'd6, 32'h7);
        rd(3'd6, d); check("R5 load no alarm", d, 0);
        load_cnt(8'h01, 32'h0000_0FFD);
        rtc_ticks(2);
        rd(3'd6, d); check("R5 before match", d, 0);
        rtc_ticks(1);
        rd(3'd6, d); check("R5 alarm set", d, 1);
        // R6: wrap warning at FF_FFFF_FF00
        wr(3'd6, 32'h7);
        load_cnt(8'hFF, 32'hFFFF_FEFE);
        rtc_ticks(1);
        rd(3'd6, d); check("R6 before warn", d, 0);
        rtc_ticks(1);
        rd(3'd6, d); check("R6 warn set", d, 4);
        rtc_ticks(3);
        rd(3'd6, d); check("R6 warn sticky", d, 4);
        // R7: period sweep, two expiries each
        wr(3'd7, 32'h2);
        for (int p = 0; p <= 9; p++) begin
            int per, expn, got;
            per  = (p == 9) ? 300 : p;
            expn = (per == 0) ? 1 : per;
            wr(3'd5, 0); wr(3'd4, per); wr(3'd5, 1); wr(3'd6, 7);
            for (int rep = 0; rep < 2; rep++) begin
                got = 0;
                for (int k = 1; k <= 400 && got == 0; k++) begin
                    tmr_one();
                    if (irq) got = k;
                end
                check("R7 expiry interval", got, expn);
                wr(3'd6, 32'h2);
            end
        end
        // R7: disabled timer ignores ticks
        wr(3'd4, 1); wr(3'd5, 0); wr(3'd6, 7);
        for (int k = 0; k < 5; k++) tmr_one();
        check("R7 disabled no expiry", {31'd0, irq}, 0);
        rd(3'd5, d); check("R7 ctrl reads 0", d, 0);
        // R8: set wins over clear in the same cycle
        wr(3'd5, 1);
        tmr_one();
        check("R8 setup", {31'd0, irq}, 1);
        @(negedge clk); bus_wr = 1; bus_addr = 3'd6; bus_wdata = 32'h2; tmr_tick = 1;
        @(negedge clk); bus_wr = 0; tmr_tick = 0;
        check("R8 set beats clear", {31'd0, irq}, 1);
        wr(3'd6, 32'h5);
        check("R8 other bits kept", {31'd0, irq}, 1);
        wr(3'd6, 32'h2);
        check("R8 cleared", {31'd0, irq}, 0);
        wr(3'd5, 0);
        // R9: mask sweep with status = 3'b111
        wr(3'd2, 32'h0000_0010); wr(3'd3, 32'h00);
        load_cnt(8'h00, 32'h0000_000F);
        rtc_ticks(1);
        load_cnt(8'hFF, 32'hFFFF_FEFF);
        rtc_ticks(1);
        wr(3'd5, 1); tmr_one(); wr(3'd5, 0);
        rd(3'd6, d); check("R9 status all", d, 7);
        for (int m = 0; m < 8; m++) begin
            wr(3'd7, m);
            check("R9 irq mask", {31'd0, irq}, (m != 0) ? 1 : 0);
        end
        wr(3'd6, 32'h1);
        wr(3'd7, 32'h1);
        check("R9 masked cleared", {31'd0, irq}, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule